// File: doc/BRIEF.md
# Colour-Filtering Pipeline Stage Controller

This block is the control shell around one stage, at position `STG_IDX`, of an instruction pipeline that has `NSTG` stages. Each instruction carries a colour vector with one bit per stage. The stage keeps its own copy of that vector and uses it to decide, for each arriving instruction, whether to execute it, forward it without executing it, or drop it. A stale prefetched instruction is removed in the stage that meets it, so the pipeline needs no global flush wire and may prefetch to any depth.

The stage's own bit and the bits of deeper stages decide the verdict. Bit index `i` ranks above bit index `j` when `i > j`. Bits of shallower stages never affect the verdict. The attached datapath can request a control transfer. The stage then inverts its own bit in its copy and offers the target address and the new vector to the address arbiter, which answers with an acknowledge or a rejection.

The datapath operation itself is not part of this block. An executed instruction travels downstream unchanged, together with a one-cycle execute strobe.

Top module: `colour_stage_ctrl`

## Requirements
- R1: After reset the stage's colour copy is all zeros, and `out_valid`, `exec_stb` and `xfer_valid` are low.
- R2: An accepted instruction whose vector differs from the copy in any bit above `STG_IDX` is forwarded without `exec_stb`, with its vector unchanged. The copy then becomes that vector.
- R3: An accepted instruction whose higher bits match the copy but whose bit `STG_IDX` differs is consumed (`in_ready` was high) and dropped. It produces no `out_valid` and no `exec_stb`.
- R4: An accepted instruction whose bits from `STG_IDX` upward all match the copy is executed. In the cycle after acceptance, `out_valid` and `exec_stb` are high, and payload and vector are unchanged.
- R5: Bits below `STG_IDX` in the incoming vector have no effect on the verdict.
- R6: A transfer request accepted while none is pending inverts bit `STG_IDX` of the copy. From the next cycle, `xfer_valid` is high with `xfer_addr` equal to the target and `xfer_colour` equal to the updated copy.
- R7: While a transfer is pending, further requests are ignored and `xfer_addr` and `xfer_colour` hold. `xfer_ack` or `xfer_rej` clears `xfer_valid` in the next cycle.
- R8: If an instruction is accepted in the same cycle as a transfer request, the instruction is judged against the copy as it was before the request. The new copy is the adopted (or kept) vector with bit `STG_IDX` inverted.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output payload and vector hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream instruction valid |
| in_ready | output | 1 | Stage can accept an instruction |
| in_payload | input | DATA_W | Upstream instruction word |
| in_colour | input | NSTG | Colour vector carried by the instruction |
| out_valid | output | 1 | Downstream instruction valid |
| out_ready | input | 1 | Downstream can accept |
| out_payload | output | DATA_W | Instruction word sent downstream |
| out_colour | output | NSTG | Vector sent downstream |
| exec_stb | output | 1 | One-cycle pulse: the held instruction was executed here |
| xfer_req | input | 1 | Datapath requests a control transfer |
| xfer_tgt | input | ADDR_W | Transfer target address |
| xfer_valid | output | 1 | Transfer offer pending at the arbiter |
| xfer_addr | output | ADDR_W | Offered target address |
| xfer_colour | output | NSTG | Offered colour vector |
| xfer_ack | input | 1 | Arbiter accepted the offer |
| xfer_rej | input | 1 | Arbiter rejected the offer |

## Verification
Two things can land in the same clock edge: an instruction being classified and the copy being updated by a transfer request. The bench provokes this by presenting an instruction whose high bit differs from the copy in the same cycle as it raises a transfer. It then expects the instruction to be forwarded, because the verdict comes from the old copy, and expects the offered vector to equal the adopted vector with the stage's bit inverted. Later instructions carrying and lacking that inverted bit confirm the copy: one is executed and the other dropped.

// File: rtl/colour_stage_pkg.sv
package colour_stage_pkg;

   typedef enum logic [1:0] {
      VERDICT_EXEC = 2'd0,
      VERDICT_PASS = 2'd1,
      VERDICT_DROP = 2'd2
   } verdict_e;

endpackage

// File: rtl/colour_classifier.sv
module colour_classifier
   import colour_stage_pkg::*;
#(
   parameter int NSTG    = 4,
   parameter int STG_IDX = 1
) (
   input  logic [NSTG-1:0] copy_q,
   input  logic [NSTG-1:0] in_colour,
   output verdict_e        verdict
);

   function automatic logic [NSTG-1:0] f_hi_mask();
      logic [NSTG-1:0] m;
      for (int i = 0; i < NSTG; i++) m[i] = (i > STG_IDX);
      return m;
   endfunction

   localparam logic [NSTG-1:0] HI_MASK = f_hi_mask();

   logic [NSTG-1:0] diff;
   logic            hi_differs;
   logic            own_differs;

   always_comb begin
      diff        = in_colour ^ copy_q;
      hi_differs  = |(diff & HI_MASK);
      own_differs = diff[STG_IDX];
      if (hi_differs)       verdict = VERDICT_PASS;
      else if (own_differs) verdict = VERDICT_DROP;
      else                  verdict = VERDICT_EXEC;
   end

endmodule

// File: rtl/colour_vector_reg.sv
module colour_vector_reg #(
   parameter int NSTG    = 4,
   parameter int STG_IDX = 1,
   parameter int ADDR_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adopt,
   input  logic [NSTG-1:0]   adopt_vec,
   input  logic              raise,
   input  logic [ADDR_W-1:0] raise_addr,
   input  logic              ack,
   input  logic              rej,
   output logic [NSTG-1:0]   copy_q,
   output logic              xfer_valid,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic [NSTG-1:0]   xfer_colour
);

   logic            take;
   logic [NSTG-1:0] copy_d;

   always_comb begin
      take   = raise && !xfer_valid;
      copy_d = adopt ? adopt_vec : copy_q;
      if (take) copy_d[STG_IDX] = ~copy_d[STG_IDX];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         copy_q      <= '0;
         xfer_valid  <= 1'b0;
         xfer_addr   <= '0;
         xfer_colour <= '0;
      end else begin
         copy_q <= copy_d;
         if (take) begin
            xfer_valid  <= 1'b1;
            xfer_addr   <= raise_addr;
            xfer_colour <= copy_d;
         end else if (ack || rej) begin
            xfer_valid  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/stage_out_reg.sv
module stage_out_reg #(
   parameter int DATA_W = 32,
   parameter int NSTG   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_exec,
   input  logic [DATA_W-1:0] d_payload,
   input  logic [NSTG-1:0]   d_colour,
   input  logic              out_ready,
   output logic              in_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_payload,
   output logic [NSTG-1:0]   out_colour,
   output logic              exec_stb
);

   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_payload <= '0;
         out_colour  <= '0;
         exec_stb    <= 1'b0;
      end else begin
         exec_stb <= load && load_exec;
         if (load) begin
            out_valid   <= 1'b1;
            out_payload <= d_payload;
            out_colour  <= d_colour;
         end else if (out_ready) begin
            out_valid   <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/colour_stage_ctrl.sv
module colour_stage_ctrl
   import colour_stage_pkg::*;
#(
   parameter int NSTG    = 4,
   parameter int STG_IDX = 1,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_payload,
   input  logic [NSTG-1:0]   in_colour,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_payload,
   output logic [NSTG-1:0]   out_colour,
   output logic              exec_stb,
   input  logic              xfer_req,
   input  logic [ADDR_W-1:0] xfer_tgt,
   output logic              xfer_valid,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic [NSTG-1:0]   xfer_colour,
   input  logic              xfer_ack,
   input  logic              xfer_rej
);

   generate
      if (NSTG < 2)             begin : g_bad_nstg   $error("NSTG must be at least 2");        end
      if (STG_IDX < 0 || STG_IDX >= NSTG)
                                begin : g_bad_idx    $error("STG_IDX must lie in 0..NSTG-1");  end
      if (DATA_W < 1)           begin : g_bad_data   $error("DATA_W must be positive");        end
      if (ADDR_W < 1)           begin : g_bad_addr   $error("ADDR_W must be positive");        end
   endgenerate

   verdict_e        verdict;
   logic [NSTG-1:0] copy_q;
   logic            accept;
   logic            adopt;
   logic            load;

   assign accept = in_valid && in_ready;
   assign adopt  = accept && (verdict == VERDICT_PASS);
   assign load   = accept && (verdict != VERDICT_DROP);

   colour_classifier #(.NSTG(NSTG), .STG_IDX(STG_IDX)) u_classify (
      .copy_q    (copy_q),
      .in_colour (in_colour),
      .verdict   (verdict)
   );

   colour_vector_reg #(.NSTG(NSTG), .STG_IDX(STG_IDX), .ADDR_W(ADDR_W)) u_vector (
      .clk         (clk),
      .rst_n       (rst_n),
      .adopt       (adopt),
      .adopt_vec   (in_colour),
      .raise       (xfer_req),
      .raise_addr  (xfer_tgt),
      .ack         (xfer_ack),
      .rej         (xfer_rej),
      .copy_q      (copy_q),
      .xfer_valid  (xfer_valid),
      .xfer_addr   (xfer_addr),
      .xfer_colour (xfer_colour)
   );

   stage_out_reg #(.DATA_W(DATA_W), .NSTG(NSTG)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (load),
      .load_exec   (verdict == VERDICT_EXEC),
      .d_payload   (in_payload),
      .d_colour    (in_colour),
      .out_ready   (out_ready),
      .in_ready    (in_ready),
      .out_valid   (out_valid),
      .out_payload (out_payload),
      .out_colour  (out_colour),
      .exec_stb    (exec_stb)
   );

endmodule

// File: rtl/colour_stage_ctrl_chk.sv
module colour_stage_ctrl_chk #(
   parameter int NSTG    = 4,
   parameter int STG_IDX = 1,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [DATA_W-1:0] in_payload,
   input logic [NSTG-1:0]   in_colour,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_payload,
   input logic [NSTG-1:0]   out_colour,
   input logic              exec_stb,
   input logic              xfer_valid,
   input logic [ADDR_W-1:0] xfer_addr,
   input logic [NSTG-1:0]   xfer_colour,
   input logic              xfer_ack,
   input logic              xfer_rej,
   input logic [NSTG-1:0]   copy_q
);

   logic acc;
   logic hi_diff;
   logic own_diff;

   always_comb begin
      acc     = in_valid && in_ready;
      hi_diff = 1'b0;
      for (int i = STG_IDX + 1; i < NSTG; i++)
         if (in_colour[i] != copy_q[i]) hi_diff = 1'b1;
      own_diff = in_colour[STG_IDX] != copy_q[STG_IDX];
   end

   // R2
   p_pass_unexecuted_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc && hi_diff |=> out_valid && !exec_stb && out_colour == $past(in_colour));

   // R3
   p_drop_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !hi_diff && own_diff |=> !out_valid && !exec_stb);

   // R4
   p_exec_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !hi_diff && !own_diff |=> out_valid && exec_stb && out_payload == $past(in_payload));

   // R4
   p_strobe_with_item_r4: assert property (@(posedge clk) disable iff (!rst_n)
      exec_stb |-> out_valid);

   // R6
   p_offer_matches_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xfer_valid) |-> xfer_colour == copy_q);

   // R7
   p_offer_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && !xfer_ack && !xfer_rej |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_colour));

   // R7
   p_offer_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && (xfer_ack || xfer_rej) |=> !xfer_valid);

   // R9
   p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_payload) && $stable(out_colour));

endmodule

bind colour_stage_ctrl colour_stage_ctrl_chk #(
   .NSTG(NSTG), .STG_IDX(STG_IDX), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_payload(in_payload), .in_colour(in_colour), .out_valid(out_valid),
   .out_ready(out_ready), .out_payload(out_payload), .out_colour(out_colour),
   .exec_stb(exec_stb), .xfer_valid(xfer_valid), .xfer_addr(xfer_addr),
   .xfer_colour(xfer_colour), .xfer_ack(xfer_ack), .xfer_rej(xfer_rej),
   .copy_q(copy_q)
);

// File: tb/colour_stage_ctrl_bench.sv
module colour_stage_ctrl_bench;

   localparam int NSTG = 4;
   localparam int K    = 1;
   localparam int DW   = 8;
   localparam int AW   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, out_ready = 1'b1, xfer_req = 1'b0, xfer_ack = 1'b0, xfer_rej = 1'b0;
   logic [DW-1:0]   in_payload = '0;
   logic [NSTG-1:0] in_colour = '0;
   logic [AW-1:0]   xfer_tgt = '0;
   logic in_ready, out_valid, exec_stb, xfer_valid;
   logic [DW-1:0]   out_payload;
   logic [NSTG-1:0] out_colour, xfer_colour;
   logic [AW-1:0]   xfer_addr;

   always #10 clk = ~clk;

   colour_stage_ctrl #(.NSTG(NSTG), .STG_IDX(K), .DATA_W(DW), .ADDR_W(AW)) u_colour_stage_ctrl (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_payload(in_payload), .in_colour(in_colour), .out_valid(out_valid),
      .out_ready(out_ready), .out_payload(out_payload), .out_colour(out_colour),
      .exec_stb(exec_stb), .xfer_req(xfer_req), .xfer_tgt(xfer_tgt),
      .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_colour(xfer_colour),
      .xfer_ack(xfer_ack), .xfer_rej(xfer_rej)
   );

   int checks = 0;
   int fails  = 0;

   logic [NSTG-1:0] mdl = '0;
   logic            x_pend = 1'b0;
   logic [AW-1:0]   x_addr = '0;
   logic [NSTG-1:0] x_col = '0;

   // expected item: {exec, colour, payload}
   logic [DW+NSTG:0] exp_q[$];
   logic             seen_exec = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (exec_stb) seen_exec = 1'b1;
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3 unexpected output", int'(out_payload), 0);
            end else begin
               logic [DW+NSTG:0] e;
               logic [DW+NSTG:0] a;
               e = exp_q.pop_front();
               a = {seen_exec, out_colour, out_payload};
               chk(a == e, "R2/R4 scoreboard item", int'(a), int'(e));
            end
            seen_exec = 1'b0;
         end
      end
   end

   task automatic send(input logic [DW-1:0] p, input logic [NSTG-1:0] c, input string tag);
      bit hi;
      bit own;
      @(negedge clk);
      in_valid = 1'b1; in_payload = p; in_colour = c;
      while (!in_ready) @(negedge clk);
      hi  = ((c ^ mdl) & 4'b1100) != 0;
      own = c[K] != mdl[K];
      if (hi) begin
         exp_q.push_back({1'b0, c, p});
         mdl = c;
      end else if (!own) begin
         exp_q.push_back({1'b1, c, p});
      end
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (!hi && own && out_ready)
         chk(!out_valid && !exec_stb, {tag, " dropped item produced output"}, int'(out_valid), 0);
   endtask

   task automatic raise(input logic [AW-1:0] a, input string tag);
      @(negedge clk);
      xfer_req = 1'b1; xfer_tgt = a;
      if (!x_pend) begin
         mdl[K] = ~mdl[K];
         x_pend = 1'b1; x_addr = a; x_col = mdl;
      end
      @(posedge clk);
      @(negedge clk);
      xfer_req = 1'b0;
      chk(xfer_valid == 1'b1, {tag, " xfer_valid"}, int'(xfer_valid), 1);
      chk(xfer_addr == x_addr, {tag, " xfer_addr"}, int'(xfer_addr), int'(x_addr));
      chk(xfer_colour == x_col, {tag, " xfer_colour"}, int'(xfer_colour), int'(x_col));
   endtask

   task automatic answer(input bit use_ack, input string tag);
      @(negedge clk);
      xfer_ack = use_ack; xfer_rej = !use_ack;
      @(posedge clk);
      @(negedge clk);
      xfer_ack = 1'b0; xfer_rej = 1'b0;
      x_pend = 1'b0;
      chk(xfer_valid == 1'b0, {tag, " xfer_valid cleared"}, int'(xfer_valid), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(!out_valid, "R1 out_valid", int'(out_valid), 0);
      chk(!exec_stb, "R1 exec_stb", int'(exec_stb), 0);
      chk(!xfer_valid, "R1 xfer_valid", int'(xfer_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready, "R9 in_ready idle", int'(in_ready), 1);

      send(8'h11, 4'b0000, "R1");           // zero copy: executes
      send(8'h12, 4'b0001, "R5");           // only a lower bit differs: executes
      raise(8'h40, "R6");                   // copy -> 0010
      raise(8'h55, "R7");                   // ignored while pending
      send(8'h13, 4'b0010, "R7");           // unchanged copy: executes
      answer(1'b1, "R7 ack");
      send(8'h14, 4'b0000, "R3");           // own bit stale: dropped
      send(8'h15, 4'b0010, "R4");
      send(8'h16, 4'b0100, "R2");           // higher bit differs: forwarded, adopted
      send(8'h17, 4'b0100, "R2");           // now matches: executes
      send(8'h18, 4'b0110, "R3");           // own bit differs: dropped
      send(8'h19, 4'b0101, "R5");           // lower bit only: executes

      // R8: arrival and transfer request in the same cycle
      @(negedge clk);
      in_valid = 1'b1; in_payload = 8'h1A; in_colour = 4'b1000;
      xfer_req = 1'b1; xfer_tgt = 8'h80;
      exp_q.push_back({1'b0, 4'b1000, 8'h1A});
      mdl = 4'b1010; x_pend = 1'b1; x_addr = 8'h80; x_col = 4'b1010;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0; xfer_req = 1'b0;
      chk(xfer_valid, "R8 xfer_valid", int'(xfer_valid), 1);
      chk(xfer_colour == 4'b1010, "R8 xfer_colour", int'(xfer_colour), 4'b1010);
      chk(xfer_addr == 8'h80, "R8 xfer_addr", int'(xfer_addr), 8'h80);
      send(8'h1B, 4'b1010, "R8");           // executes
      send(8'h1C, 4'b1000, "R8");           // dropped
      answer(1'b0, "R7 rej");

      // R9: backpressure
      @(posedge clk);
      out_ready <= 1'b0;
      send(8'h1D, 4'b1010, "R9");
      for (int i = 0; i < 3; i++) begin
         chk(out_valid && !in_ready, "R9 held, in_ready low", int'({out_valid, in_ready}), 2);
         chk(out_payload == 8'h1D, "R9 payload stable", int'(out_payload), 8'h1D);
         @(negedge clk);
      end
      @(posedge clk);
      out_ready <= 1'b1;
      repeat (3) @(negedge clk);

      chk(exp_q.size() == 0, "R4 all expected items delivered", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule